// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Model

This block is a synthesizable model of a 1 Kbit non-volatile memory that a host reaches over a three-wire serial bus: a select line, a serial clock and a data input, plus one data output. The memory runs off the chip's system clock and oversamples the serial clock, so the serial side may be any rate well below the system clock. Each transaction opens with a start bit, then carries a two-bit opcode and an address. Depending on the opcode, it then returns read data, takes write data, or takes nothing more.

Reading, single-location writing and erasing, filling the whole array, and wiping the whole array are supported. Two further commands set and clear a write-enable latch. A programming command takes effect when the select line drops after a complete frame. The device then stays busy for a parameterised number of system clocks. It reports that state on the data output whenever the host selects it without sending a new command.

A single parameter chooses 16-bit words (64 locations, 6-bit address) or 8-bit bytes (128 locations, 7-bit address). The storage is held in registers and resets to the erased state.

Top module: `sernvm_dev`

## Requirements
- R1: After reset, every location reads all ones, the write-enable latch is clear, the output is 0 while deselected, and the output is 1 (ready) as soon as select rises.
- R2: Bits are taken on the rising serial clock while select is high. Leading 0 bits are skipped. The first 1 is the start bit, followed MSB first by a 2-bit opcode and the address (6 bits in word mode, 7 in byte mode).
- R3: Opcode 10 (read): a 0 is driven after the last address bit, then the stored value follows MSB first, each bit updated on a rising serial clock so that it is valid at the next one.
- R4: Opcode 00 with the address MSBs at 11 sets the write-enable latch, and 00 clears it. While the latch is clear, no programming command alters memory or starts a busy period.
- R5: Opcode 01 (write) takes one data value MSB first after the address and stores it at that address when select falls.
- R6: Opcode 11 (erase) sets the addressed location to all ones when select falls.
- R7: Opcode 00 with address MSBs 01 takes one data value and loads it into every location when select falls.
- R8: Opcode 00 with address MSBs 10 sets every location to all ones when select falls.
- R9: After a programming command starts, the output is 0 whenever select is high and no frame is in progress, and it becomes 1 after BUSY_CYCLES system clocks.
- R10: While busy, start bits are ignored: a read attempt returns only 0s and memory is unchanged.
- R11: Dropping select before a frame is complete discards it: no busy period starts and memory is unchanged.
- R12: With BYTE_MODE set, values are 8 bits wide and the address is 7 bits, so all 128 locations are reachable and distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Device select, active high |
| sck_i | input | 1 | Serial clock, oversampled by clk |
| sdi_i | input | 1 | Serial data into the device |
| sdo_o | output | 1 | Serial data out / ready status |

## Verification
The bench holds two instances side by side. One is in word mode with BUSY_CYCLES of 400. The other is in byte mode with BUSY_CYCLES of 150. The long word-mode busy time leaves room for a complete read frame to be sent while the device is still busy, so the ignore-while-busy rule can be seen at the port. The byte-mode instance exercises the 10-clock header, the 8-bit data path and addresses 64 to 127, which word mode cannot reach.

// File: rtl/sernvm_pkg.sv
package sernvm_pkg;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_ERASE   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SP_LOCK   = 2'b00,
    SP_FILL   = 2'b01,
    SP_CLEAR  = 2'b10,
    SP_UNLOCK = 2'b11
  } sp_e;

  typedef enum logic [1:0] {
    PG_ONE,
    PG_WIPE,
    PG_ALL,
    PG_WIPE_ALL
  } pg_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_HEAD,
    FR_DATA,
    FR_READ,
    FR_ARMED,
    FR_DONE
  } fr_st_e;

  function automatic int word_bits(bit byte_mode);
    return byte_mode ? 8 : 16;
  endfunction

  function automatic bit pg_targets(pg_e k, int a, int i);
    return (k == PG_ALL) || (k == PG_WIPE_ALL) || (a == i);
  endfunction

  function automatic bit pg_wipes(pg_e k);
    return (k == PG_WIPE) || (k == PG_WIPE_ALL);
  endfunction

endpackage

// File: rtl/sernvm_edge.sv
module sernvm_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic hit
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign hit = q & ~lvl;
    end else begin : g_rise
      assign hit = lvl & ~q;
    end
  endgenerate
endmodule

// File: rtl/sernvm_frame.sv
module sernvm_frame
  import sernvm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_i,
  input  logic          cs_fall,
  input  logic          sck_rise,
  input  logic          sdi,
  input  logic          busy,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  output logic          frame_idle,
  output logic          rd_active,
  output logic          wel,
  output logic          pg_go,
  output pg_e           pg_kind,
  output logic [AW-1:0] pg_addr,
  output logic [DW-1:0] pg_data
);
  localparam int HB = 2 + AW;
  localparam int MAXB = (HB > DW) ? HB : DW;
  localparam int CW = $clog2(MAXB + 1);

  fr_st_e        st;
  logic [CW-1:0] cnt;
  logic [HB-2:0] hdr;
  logic [HB-1:0] nh;
  logic [DW-1:0] rd_sh;
  logic [1:0]    nh_op;
  logic [1:0]    nh_sp;

  assign nh         = {hdr, sdi};
  assign nh_op      = nh[HB-1 -: 2];
  assign nh_sp      = nh[AW-1 -: 2];
  assign rd_addr    = nh[AW-1:0];
  assign frame_idle = (st == FR_IDLE);
  assign rd_active  = (st == FR_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FR_IDLE;
      cnt     <= '0;
      hdr     <= '0;
      rd_sh   <= '0;
      rd_bit  <= 1'b0;
      wel     <= 1'b0;
      pg_go   <= 1'b0;
      pg_kind <= PG_ONE;
      pg_addr <= '0;
      pg_data <= '0;
    end else begin
      pg_go <= 1'b0;
      if (!cs_i) begin
        st     <= FR_IDLE;
        cnt    <= '0;
        rd_bit <= 1'b0;
        if (cs_fall && st == FR_ARMED && wel) pg_go <= 1'b1;
      end else if (sck_rise) begin
        unique case (st)
          FR_IDLE: begin
            if (sdi && !busy) begin
              st  <= FR_HEAD;
              cnt <= '0;
              hdr <= '0;
            end
          end
          FR_HEAD: begin
            hdr <= nh[HB-2:0];
            cnt <= cnt + 1'b1;
            if (cnt == CW'(HB - 1)) begin
              cnt     <= '0;
              pg_addr <= nh[AW-1:0];
              unique case (nh_op)
                OP_READ: begin
                  st     <= FR_READ;
                  rd_sh  <= rd_word;
                  rd_bit <= 1'b0;
                end
                OP_WRITE: begin
                  pg_kind <= PG_ONE;
                  st      <= FR_DATA;
                end
                OP_ERASE: begin
                  pg_kind <= PG_WIPE;
                  st      <= FR_ARMED;
                end
                default: begin
                  unique case (nh_sp)
                    SP_LOCK: begin
                      wel <= 1'b0;
                      st  <= FR_DONE;
                    end
                    SP_UNLOCK: begin
                      wel <= 1'b1;
                      st  <= FR_DONE;
                    end
                    SP_FILL: begin
                      pg_kind <= PG_ALL;
                      st      <= FR_DATA;
                    end
                    default: begin
                      pg_kind <= PG_WIPE_ALL;
                      st      <= FR_ARMED;
                    end
                  endcase
                end
              endcase
            end
          end
          FR_DATA: begin
            pg_data <= {pg_data[DW-2:0], sdi};
            cnt     <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) st <= FR_ARMED;
          end
          FR_READ: begin
            rd_bit <= rd_sh[DW-1];
            rd_sh  <= {rd_sh[DW-2:0], 1'b0};
          end
          default: begin
            st <= st;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sernvm_store.sv
module sernvm_store
  import sernvm_pkg::*;
#(
  parameter int DW          = 16,
  parameter int AW          = 6,
  parameter int BUSY_CYCLES = 400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg_go,
  input  pg_e           pg_kind,
  input  logic [AW-1:0] pg_addr,
  input  logic [DW-1:0] pg_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word,
  output logic          busy
);
  localparam int DEPTH = 1 << AW;
  localparam int BCW   = $clog2(BUSY_CYCLES + 2);

  logic [DW-1:0]  mem [DEPTH];
  logic [BCW-1:0] bcnt;
  logic [DW-1:0]  pg_val;

  assign pg_val  = pg_wipes(pg_kind) ? '1 : pg_data;
  assign rd_word = mem[rd_addr];
  assign busy    = (bcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else begin
      if (bcnt != '0) bcnt <= bcnt - 1'b1;
      if (pg_go) begin
        bcnt <= BCW'(BUSY_CYCLES);
        for (int i = 0; i < DEPTH; i++) begin
          if (pg_targets(pg_kind, int'(pg_addr), i)) mem[i] <= pg_val;
        end
      end
    end
  end
endmodule

// File: rtl/sernvm_dev.sv
module sernvm_dev
  import sernvm_pkg::*;
#(
  parameter bit BYTE_MODE   = 1'b0,
  parameter int BUSY_CYCLES = 400,
  parameter int TOTAL_BITS  = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o
);
  localparam int DW    = word_bits(BYTE_MODE);
  localparam int DEPTH = TOTAL_BITS / DW;
  localparam int AW    = $clog2(DEPTH);

  logic          sck_rise;
  logic          cs_fall;
  logic          busy;
  logic          frm_idle;
  logic          rd_act;
  logic          rd_bit;
  logic          wel;
  logic          pg_go;
  pg_e           pg_kind;
  logic [AW-1:0] pg_addr;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] pg_data;
  logic [DW-1:0] rd_word;

  sernvm_edge #(.FALLING(1'b0)) u_sck_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sck_i), .hit(sck_rise)
  );

  sernvm_edge #(.FALLING(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .lvl(cs_i), .hit(cs_fall)
  );

  sernvm_frame #(.DW(DW), .AW(AW)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sdi(sdi_i), .busy(busy), .rd_word(rd_word),
    .rd_addr(rd_addr), .rd_bit(rd_bit), .frame_idle(frm_idle),
    .rd_active(rd_act), .wel(wel), .pg_go(pg_go), .pg_kind(pg_kind),
    .pg_addr(pg_addr), .pg_data(pg_data)
  );

  sernvm_store #(.DW(DW), .AW(AW), .BUSY_CYCLES(BUSY_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .pg_go(pg_go), .pg_kind(pg_kind),
    .pg_addr(pg_addr), .pg_data(pg_data), .rd_addr(rd_addr),
    .rd_word(rd_word), .busy(busy)
  );

  always_comb begin
    if (!cs_i)         sdo_o = 1'b0;
    else if (frm_idle) sdo_o = ~busy;
    else if (rd_act)   sdo_o = rd_bit;
    else               sdo_o = 1'b0;
  end
endmodule

// File: rtl/sernvm_chk.sv
module sernvm_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_i,
  input logic sdo_o,
  input logic busy,
  input logic frame_idle,
  input logic rd_active,
  input logic wel,
  input logic pg_go
);
  // R10: a busy device never leaves the idle frame state
  a_r10_busy_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> frame_idle);

  // R4: a programming launch only with the latch set
  a_r4_launch_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    pg_go |-> wel);

  // R9: a launch is followed by busy
  a_r9_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
    pg_go |=> busy);

  // R11: deselect returns the frame to idle
  a_r11_deselect_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> frame_idle);

  // R1: output quiet while deselected
  a_r1_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> !sdo_o);

  // R3: a read never overlaps a busy period
  a_r3_read_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !busy);
endmodule

bind sernvm_dev sernvm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sdo_o(sdo_o), .busy(busy),
  .frame_idle(frm_idle), .rd_active(rd_act), .wel(wel), .pg_go(pg_go)
);

// File: tb/sernvm_dev_bench.sv
`timescale 1ns/1ps
module sernvm_dev_bench;
  localparam int BUSY_W = 400;
  localparam int BUSY_B = 150;
  localparam int H      = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic cs_w = 1'b0;
  logic cs_b = 1'b0;
  logic sdo_w;
  logic sdo_b;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  sernvm_dev #(.BYTE_MODE(1'b0), .BUSY_CYCLES(BUSY_W)) u_sernvm_dev (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_w), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo_w)
  );

  sernvm_dev #(.BYTE_MODE(1'b1), .BUSY_CYCLES(BUSY_B)) u_sernvm_dev_byte (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_b), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo_b)
  );

  function automatic int dwf(bit b);
    return b ? 8 : 16;
  endfunction

  function automatic int awf(bit b);
    return b ? 7 : 6;
  endfunction

  function automatic logic get_sdo(bit b);
    return b ? sdo_b : sdo_w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cs(bit b, logic v);
    if (b) cs_b = v;
    else   cs_w = v;
  endtask

  task automatic tick(bit b, logic d, output logic s);
    sdi = d;
    repeat (H) @(negedge clk);
    s = get_sdo(b);
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic head(bit b, logic [1:0] op, logic [6:0] a, int lead);
    logic s;
    set_cs(b, 1'b1);
    @(negedge clk);
    repeat (lead) tick(b, 1'b0, s);
    tick(b, 1'b1, s);
    tick(b, op[1], s);
    tick(b, op[0], s);
    for (int i = awf(b) - 1; i >= 0; i--) tick(b, a[i], s);
  endtask

  task automatic end_frame(bit b);
    repeat (H) @(negedge clk);
    set_cs(b, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(bit b, logic [6:0] a, int lead, output logic [15:0] d, output logic dummy);
    logic s;
    head(b, 2'b10, a, lead);
    tick(b, 1'b0, dummy);
    d = '0;
    for (int i = 0; i < dwf(b); i++) begin
      tick(b, 1'b0, s);
      d = {d[14:0], s};
    end
    end_frame(b);
  endtask

  task automatic wr(bit b, logic [1:0] op, logic [6:0] a, logic [15:0] d, int nbits);
    logic s;
    head(b, op, a, 0);
    for (int i = 0; i < nbits; i++) tick(b, d[dwf(b) - 1 - i], s);
    end_frame(b);
  endtask

  task automatic special(bit b, logic [1:0] code, logic [15:0] d, int nbits);
    logic [6:0] a;
    a = 7'(code) << (awf(b) - 2);
    wr(b, 2'b00, a, d, nbits);
  endtask

  task automatic ready_time(bit b, output int n);
    set_cs(b, 1'b1);
    n = 0;
    @(negedge clk);
    while (get_sdo(b) !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    set_cs(b, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_read(bit b, logic [6:0] a, logic [15:0] exp, string req);
    logic [15:0] d;
    logic dm;
    rd(b, a, 0, d, dm);
    chk({req, " dummy"}, dm, 1'b0);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    int n;
    logic [15:0] d;
    logic dm;
    chk("R1 sdo word deselected", sdo_w, 1'b0);
    chk("R1 sdo byte deselected", sdo_b, 1'b0);
    ready_time(1'b0, n);
    chk("R1 ready at select", n, 0);
    rd(1'b0, 7'd5, 2, d, dm);
    chk("R2 R3 lead zeros dummy bit", dm, 1'b0);
    chk("R1 erased after reset", d, 16'hFFFF);
  endtask

  task automatic t_wel_gate();
    int n;
    wr(1'b0, 2'b01, 7'd3, 16'h1234, 16);
    ready_time(1'b0, n);
    chk("R4 no busy when latch clear", n, 0);
    expect_read(1'b0, 7'd3, 16'hFFFF, "R4 write blocked");
  endtask

  task automatic t_write_read();
    int n;
    special(1'b0, 2'b11, 16'h0, 0);
    wr(1'b0, 2'b01, 7'd3, 16'hA5C3, 16);
    ready_time(1'b0, n);
    chk("R9 busy window", (n >= BUSY_W - 10 && n <= BUSY_W), 1'b1);
    expect_read(1'b0, 7'd3, 16'hA5C3, "R5 write read back");
    wr(1'b0, 2'b01, 7'd63, 16'h0001, 16);
    ready_time(1'b0, n);
    wr(1'b0, 2'b01, 7'd0, 16'h8000, 16);
    ready_time(1'b0, n);
    expect_read(1'b0, 7'd63, 16'h0001, "R2 top address");
    expect_read(1'b0, 7'd0, 16'h8000, "R3 msb first");
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [15:0] d;
    logic dm;
    wr(1'b0, 2'b01, 7'd10, 16'h1111, 16);
    set_cs(1'b0, 1'b1);
    @(negedge clk);
    chk("R9 sdo low while busy", sdo_w, 1'b0);
    set_cs(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rd(1'b0, 7'd3, 0, d, dm);
    chk("R10 read while busy dummy", dm, 1'b0);
    chk("R10 read while busy", d, 16'h0000);
    ready_time(1'b0, n);
    expect_read(1'b0, 7'd3, 16'hA5C3, "R10 memory unchanged");
    expect_read(1'b0, 7'd10, 16'h1111, "R5 second write");
  endtask

  task automatic t_erase();
    int n;
    wr(1'b0, 2'b11, 7'd3, 16'h0, 0);
    ready_time(1'b0, n);
    chk("R6 erase busy", (n > 0), 1'b1);
    expect_read(1'b0, 7'd3, 16'hFFFF, "R6 erased location");
    expect_read(1'b0, 7'd10, 16'h1111, "R6 neighbour kept");
  endtask

  task automatic t_abort();
    int n;
    logic s;
    wr(1'b0, 2'b01, 7'd10, 16'h0F0F, 8);
    ready_time(1'b0, n);
    chk("R11 no busy after data abort", n, 0);
    set_cs(1'b0, 1'b1);
    @(negedge clk);
    tick(1'b0, 1'b1, s);
    tick(1'b0, 1'b1, s);
    tick(1'b0, 1'b1, s);
    end_frame(1'b0);
    ready_time(1'b0, n);
    chk("R11 no busy after header abort", n, 0);
    expect_read(1'b0, 7'd10, 16'h1111, "R11 memory unchanged");
  endtask

  task automatic t_fill_wipe();
    int n;
    special(1'b0, 2'b01, 16'h3C3C, 16);
    ready_time(1'b0, n);
    chk("R7 fill busy", (n > 0), 1'b1);
    expect_read(1'b0, 7'd0, 16'h3C3C, "R7 fill addr 0");
    expect_read(1'b0, 7'd63, 16'h3C3C, "R7 fill addr 63");
    expect_read(1'b0, 7'd20, 16'h3C3C, "R7 fill addr 20");
    special(1'b0, 2'b10, 16'h0, 0);
    ready_time(1'b0, n);
    expect_read(1'b0, 7'd0, 16'hFFFF, "R8 wipe addr 0");
    expect_read(1'b0, 7'd63, 16'hFFFF, "R8 wipe addr 63");
  endtask

  task automatic t_disable();
    int n;
    wr(1'b0, 2'b01, 7'd7, 16'h0042, 16);
    ready_time(1'b0, n);
    special(1'b0, 2'b00, 16'h0, 0);
    special(1'b0, 2'b10, 16'h0, 0);
    ready_time(1'b0, n);
    chk("R4 wipe blocked no busy", n, 0);
    expect_read(1'b0, 7'd7, 16'h0042, "R4 lock keeps data");
  endtask

  task automatic t_byte_mode();
    int n;
    special(1'b1, 2'b11, 16'h0, 0);
    wr(1'b1, 2'b01, 7'd127, 16'h009A, 8);
    ready_time(1'b1, n);
    chk("R12 byte busy window", (n >= BUSY_B - 10 && n <= BUSY_B), 1'b1);
    wr(1'b1, 2'b01, 7'd0, 16'h0001, 8);
    ready_time(1'b1, n);
    wr(1'b1, 2'b01, 7'd64, 16'h0055, 8);
    ready_time(1'b1, n);
    expect_read(1'b1, 7'd127, 16'h009A, "R12 byte top address");
    expect_read(1'b1, 7'd0, 16'h0001, "R12 byte addr 0 distinct");
    expect_read(1'b1, 7'd64, 16'h0055, "R12 byte addr 64");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset_pre();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_wel_gate();
    t_write_read();
    t_busy_ignore();
    t_erase();
    t_abort();
    t_fill_wipe();
    t_disable();
    t_byte_mode();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic t_reset_pre();
    chk("R1 sdo low in reset", sdo_w, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule